// File: doc/BRIEF.md
# Destination Address Filter

This block sits in a receive path and decides, from the destination address at the head of each incoming frame, whether the frame is kept. A frame is taken when promiscuous mode is on, when its destination equals the programmed station address, when it is the all-ones broadcast address and broadcast reception is allowed, or when it is a group address whose hash selects a set bit in a 64-bit table. The block does not store frames. It only produces a verdict and a group-address flag, which the receive logic can use as its status.

A frame begins with a one-cycle `frm_start` pulse. The destination bytes then arrive, one per cycle in which `byte_vld` is high, first byte first, and gaps are allowed. The number of address bytes comes from a 3-bit length field that is sampled at `frm_start`. The station address and the hash table are loaded one byte at a time through a small write port.

The hash is a CRC-32 over the address bytes. It uses the reflected polynomial 0xEDB88320, starts from all ones, shifts each byte in LSB first and applies no final inversion. The table index is bits 31..26 of the resulting register, with bit 31 as the index MSB.

Top module: `dst_addr_filter`

## Requirements
- R1: The effective address length is `cfg_alen`, except that the value 7 means 0. It is latched at `frm_start`. With length 0, `dec_vld` pulses in the cycle after `frm_start` with `accept`=1 and `mcast`=0.
- R2: For a length L>0, `dec_vld` is high for exactly one cycle: the cycle after the clock edge at which the L-th address byte (`byte_vld`=1) was taken. Further bytes before the next `frm_start` are ignored. A `byte_vld` in the same cycle as `frm_start` is ignored.
- R3: When `cfg_promisc`=1 at the deciding edge, the frame is accepted.
- R4: A frame whose L address bytes equal station address bytes 0..L-1 is accepted. Station byte k is written with `set_we`=1, `set_sel`=0 and `set_idx`=k, and byte 0 is compared with the first address byte.
- R5: A destination whose L bytes are all 0xFF is a broadcast. It bypasses the hash and is accepted by this path only when `cfg_bc_dis`=0.
- R6: A non-broadcast address with bit 0 of its first byte set is a group address. It is accepted when table bit `crc[31:26]` is 1.
- R7: A non-broadcast address that is not a group address, does not match the station address and arrives with promiscuous mode off is rejected.
- R8: `mcast` equals `accept` AND bit 0 of the first address byte. `accept` and `mcast` keep their values from one decision to the next.
- R9: Writing `set_we`=1, `set_sel`=1 and `set_idx`=k loads `set_data` into table bits 8k+7..8k.
- R10: After reset, `dec_vld`, `accept` and `mcast` are 0, and address bytes arriving before any `frm_start` produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Start of a frame's address |
| byte_vld | input | 1 | Address byte present on byte_in |
| byte_in | input | 8 | Destination address byte |
| cfg_alen | input | 3 | Address length in bytes, 7 means 0 |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bc_dis | input | 1 | Refuse the all-ones address |
| set_we | input | 1 | Setup write strobe |
| set_sel | input | 1 | 0 station address, 1 hash table |
| set_idx | input | SET_IDX_W | Byte index of the setup write |
| set_data | input | 8 | Setup write byte |
| dec_vld | output | 1 | Verdict valid pulse |
| accept | output | 1 | Frame accepted |
| mcast | output | 1 | Accepted group-address frame |

## Verification
The bench builds the block with its default parameters: six address bytes and a 6-bit hash index, so 64 table bits. This puts every length from 0 to 6, the 7-means-0 case and every table bit within reach. The bench computes the CRC index of chosen group addresses itself, so it can set exactly the hit bit, or every bit except it. Randomised frames then mix lengths, gaps between bytes, promiscuous and broadcast settings, and station-address prefixes against the behavioural model.

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  parameter int SET_IDX_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_start,
  input  logic                 byte_vld,
  input  logic [7:0]           byte_in,
  input  logic [2:0]           cfg_alen,
  input  logic                 cfg_promisc,
  input  logic                 cfg_bc_dis,
  input  logic                 set_we,
  input  logic                 set_sel,
  input  logic [SET_IDX_W-1:0] set_idx,
  input  logic [7:0]           set_data,
  output logic                 dec_vld,
  output logic                 accept,
  output logic                 mcast
);
  localparam int HASH_SIZE  = 1 << HASH_IDX_W;
  localparam int HASH_BYTES = HASH_SIZE / 8;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic [ADDR_BYTES*8-1:0] ia_q;
  logic [HASH_SIZE-1:0]    htab_q;

  logic        active_q, ia_ok_q, bc_ok_q, grp_q;
  logic [2:0]  cnt_q, len_q;
  logic [31:0] crc_q;
  logic        dec_q, acc_q, mc_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  genvar k;
  generate
    for (k = 0; k < ADDR_BYTES; k++) begin : g_ia
      always_ff @(posedge clk)
        if (!rst_n) ia_q[k*8 +: 8] <= '0;
        else if (set_we && !set_sel && set_idx == SET_IDX_W'(k)) ia_q[k*8 +: 8] <= set_data;
    end
    for (k = 0; k < HASH_BYTES; k++) begin : g_ht
      always_ff @(posedge clk)
        if (!rst_n) htab_q[k*8 +: 8] <= '0;
        else if (set_we && set_sel && set_idx == SET_IDX_W'(k)) htab_q[k*8 +: 8] <= set_data;
    end
  endgenerate

  wire [2:0]  alen_eff = (cfg_alen == 3'd7) ? 3'd0 : cfg_alen;
  wire [31:0] crc_n    = crc_step(crc_q, byte_in);
  wire [7:0]  ia_byte  = ia_q[cnt_q*8 +: 8];
  wire        ia_n     = ia_ok_q & (byte_in == ia_byte);
  wire        bc_n     = bc_ok_q & (byte_in == 8'hFF);
  wire        grp_n    = (cnt_q == 3'd0) ? byte_in[0] : grp_q;
  wire        hash_hit = htab_q[crc_n[31 -: HASH_IDX_W]];
  wire        acc_n    = cfg_promisc | ia_n | (bc_n ? ~cfg_bc_dis : (grp_n & hash_hit));
  wire        last     = (cnt_q + 3'd1) == len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      crc_q    <= '1;
      ia_ok_q  <= 1'b0;
      bc_ok_q  <= 1'b0;
      grp_q    <= 1'b0;
      dec_q    <= 1'b0;
      acc_q    <= 1'b0;
      mc_q     <= 1'b0;
    end else begin
      dec_q <= 1'b0;
      if (frm_start) begin
        len_q    <= alen_eff;
        cnt_q    <= '0;
        crc_q    <= '1;
        ia_ok_q  <= 1'b1;
        bc_ok_q  <= 1'b1;
        grp_q    <= 1'b0;
        active_q <= (alen_eff != 3'd0);
        if (alen_eff == 3'd0) begin
          dec_q <= 1'b1;
          acc_q <= 1'b1;
          mc_q  <= 1'b0;
        end
      end else if (byte_vld && active_q) begin
        cnt_q   <= cnt_q + 3'd1;
        crc_q   <= crc_n;
        ia_ok_q <= ia_n;
        bc_ok_q <= bc_n;
        grp_q   <= grp_n;
        if (last) begin
          active_q <= 1'b0;
          dec_q    <= 1'b1;
          acc_q    <= acc_n;
          mc_q     <= acc_n & grp_n;
        end
      end
    end
  end

  assign dec_vld = dec_q;
  assign accept  = acc_q;
  assign mcast   = mc_q;
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_start,
  input logic       byte_vld,
  input logic [2:0] cfg_alen,
  input logic       cfg_promisc,
  input logic       dec_vld,
  input logic       accept,
  input logic       mcast
);
  p_zero_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && cfg_alen == 3'd7 |=> dec_vld && accept && !mcast);

  p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(frm_start || byte_vld));

  p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !frm_start && cfg_promisc |=> !dec_vld || accept);

  p_mcast_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mcast |-> accept);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> $stable(accept) && $stable(mcast));
endmodule

bind dst_addr_filter addr_filter_chk u_chk (.*);

// File: tb/sim_dst_addr_filter.sv
module sim_dst_addr_filter;
  logic clk = 0, rst_n = 0;
  logic frm_start = 0, byte_vld = 0, cfg_promisc = 0, cfg_bc_dis = 0;
  logic set_we = 0, set_sel = 0;
  logic [7:0] byte_in = 0, set_data = 0;
  logic [2:0] cfg_alen = 3'd6, set_idx = 0;
  logic dec_vld, accept, mcast;

  always #4 clk = ~clk;

  dst_addr_filter u0 (.*);

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R10";

  byte unsigned m_ia[6];
  bit m_ht[64];
  byte unsigned q[$];
  bit m_active = 0;
  int m_len = 0;
  bit e_vld = 0, e_acc = 0, e_mc = 0;

  function automatic int hidx(byte unsigned a[$]);
    bit [31:0] c = 32'hFFFFFFFF;
    foreach (a[i]) begin
      c ^= {24'd0, a[i]};
      repeat (8) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return int'(c >> 26);
  endfunction

  task automatic decide();
    bit ia = 1, bc = 1, grp;
    foreach (q[i]) begin
      if (q[i] != m_ia[i]) ia = 0;
      if (q[i] != 8'hFF) bc = 0;
    end
    grp = q[0][0];
    e_vld = 1;
    e_acc = cfg_promisc || ia || (bc ? !cfg_bc_dis : (grp && m_ht[hidx(q)]));
    e_mc  = e_acc && grp;
  endtask

  task automatic model();
    e_vld = 0;
    if (!rst_n) begin
      m_active = 0; e_acc = 0; e_mc = 0;
      foreach (m_ia[i]) m_ia[i] = 0;
      foreach (m_ht[i]) m_ht[i] = 0;
      return;
    end
    if (frm_start) begin
      m_len = (cfg_alen == 7) ? 0 : cfg_alen;
      q.delete();
      m_active = (m_len != 0);
      if (m_len == 0) begin e_vld = 1; e_acc = 1; e_mc = 0; end
    end else if (byte_vld && m_active) begin
      q.push_back(byte_in);
      if (q.size() == m_len) begin m_active = 0; decide(); end
    end
    if (set_we) begin
      if (!set_sel && set_idx < 6) m_ia[set_idx] = set_data;
      if (set_sel) for (int b = 0; b < 8; b++) m_ht[set_idx*8 + b] = set_data[b];
    end
  endtask

  task automatic chk(string what, bit act, bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(bit fs, bit bv, byte unsigned b);
    frm_start = fs; byte_vld = bv; byte_in = b;
    @(posedge clk);
    model();
    @(negedge clk);
    chk("dec_vld", dec_vld, e_vld);
    chk("accept", accept, e_acc);
    chk("mcast", mcast, e_mc);
    frm_start = 0; byte_vld = 0; set_we = 0;
  endtask

  task automatic wr(bit sel, int idx, byte unsigned d);
    set_we = 1; set_sel = sel; set_idx = 3'(idx); set_data = d;
    tick(0, 0, 0);
  endtask

  task automatic frame(bit [47:0] a, int gap = 0);
    tick(1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      tick(0, 1, a[47 - 8*i -: 8]);
      for (int g = 0; g < gap; g++) tick(0, 0, 8'hA5);
    end
    tick(0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    tick(0, 0, 0);
    rst_n = 1;
    tag = "R10";
    tick(0, 0, 0);
    tick(0, 1, 8'h02); tick(0, 1, 8'hFF); tick(0, 1, 8'h11);

    tag = "R4";
    wr(0, 0, 8'h02); wr(0, 1, 8'h11); wr(0, 2, 8'h22);
    wr(0, 3, 8'h33); wr(0, 4, 8'h44); wr(0, 5, 8'h55);
    frame(48'h021122334455);
    tag = "R7";
    frame(48'h021122334456);
    frame(48'h9C0000000001);
    tag = "R5";
    frame(48'hFFFFFFFFFFFF);
    cfg_bc_dis = 1;
    frame(48'hFFFFFFFFFFFF);
    tag = "R3";
    cfg_promisc = 1;
    frame(48'hFFFFFFFFFFFF);
    frame(48'h400000000000);
    cfg_promisc = 0; cfg_bc_dis = 0;

    tag = "R6";
    frame(48'h01005E000001);
    tag = "R9";
    for (int k = 0; k < 8; k++) wr(1, k, 8'hFF);
    tag = "R8";
    frame(48'h01005E000001);
    tag = "R9";
    begin
      byte unsigned a[$] = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
      int ix = hidx(a);
      for (int k = 0; k < 8; k++) wr(1, k, (k == ix / 8) ? 8'(1 << (ix % 8)) : 8'h00);
      tag = "R6";
      frame(48'h01005E000001);
      tag = "R9";
      for (int k = 0; k < 8; k++) wr(1, k, (k == ix / 8) ? ~8'(1 << (ix % 8)) : 8'hFF);
      tag = "R6";
      frame(48'h01005E000001);
    end

    tag = "R1";
    cfg_alen = 3'd7;
    tick(1, 0, 0); tick(0, 1, 8'h77); tick(0, 0, 0);
    cfg_alen = 3'd0;
    tick(1, 0, 0); tick(0, 0, 0);
    tag = "R2";
    cfg_alen = 3'd2;
    frame(48'h0211AABBCCDD, 1);
    tick(1, 1, 8'h02); tick(0, 1, 8'h11); tick(0, 1, 8'h22); tick(0, 0, 0);
    cfg_alen = 3'd3;
    frame(48'h0300FF000000, 2);

    tag = "R8";
    for (int n = 0; n < 60; n++) begin
      bit [47:0] a = {$urandom, $urandom};
      cfg_alen = 3'($urandom_range(0, 7));
      cfg_promisc = ($urandom_range(0, 5) == 0);
      cfg_bc_dis = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: a = 48'h021122334455 ^ (48'd1 << $urandom_range(0, 47));
        1: a = 48'h021122334455;
        2: a = 48'hFFFFFFFFFFFF;
        default: ;
      endcase
      if (n == 30) for (int k = 0; k < 8; k++) wr(1, k, 8'($urandom));
      frame(a, $urandom_range(0, 1));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule